// File: doc/BRIEF.md
# Register Step and Literal-OR Execute Unit

This unit is the execute stage of a small 8-bit accumulator core. Each cycle it may be handed one operation. It steps a file register up or down by one, or it ORs an 8-bit literal into the working register W. The register file sits outside the unit. The unit presents the operand address combinationally, takes the read data back, and drives a write port that the file captures on the clock edge that closes the cycle.

A stepped result goes to one of two places, chosen by a destination bit on every operation: W, or the same file entry it was read from. Plain steps refresh the zero flag. The skip-on-zero steps leave the status register alone and raise a skip request when the 8-bit result is zero, so that the fetch logic can turn the instruction already fetched into a bubble. The OR operation always writes W and refreshes the zero flag.

W and the status register live in the unit and are cleared by a synchronous reset.

Top module: `incdec_exec`

## Requirements
- R1: While `rst` is high at a clock edge, W and the status register are both cleared to zero at that edge, and the unit requests no file write and no skip.
- R2: Arithmetic is modulo 256. Step-up yields (f+1) mod 256, so 0xFF becomes 0x00. Step-down yields (f+255) mod 256, so 0x00 becomes 0xFF.
- R3: For a step operation (codes 1 to 4), destination bit 0 loads the result into W at the closing edge and asserts no file write. Destination bit 1 asserts `rf_we` with `rf_waddr` equal to the operand address, and leaves W unchanged.
- R4: Plain step-up (code 1) and plain step-down (code 2) set status bit 2 (zero) exactly when the result is 0x00 and keep every other status bit.
- R5: Skip step-up (code 3) and skip step-down (code 4) leave the whole status register unchanged.
- R6: `skip_req` is high during the cycle of a valid code 3 or code 4 operation whose result is 0x00, and low in every other case.
- R7: Literal OR (code 5) loads W with W OR `op_lit`, sets status bit 2 when that value is zero and clears it otherwise, never writes the file, and ignores the destination bit.
- R8: When `op_valid` is low, or when the code is 0, 6 or 7, there is no file write and no skip, and W and status keep their values.
- R9: `rf_raddr` always equals `op_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 3 | 1 step-up, 2 step-down, 3 skip step-up, 4 skip step-down, 5 literal OR, others no-op |
| op_addr | input | 5 | File register address |
| op_dst | input | 1 | 0 sends the result to W, 1 sends it to the file register |
| op_lit | input | 8 | Literal for the OR operation |
| rf_raddr | output | 5 | File read address |
| rf_rdata | input | 8 | File read data for `rf_raddr` |
| rf_we | output | 1 | File write enable, captured on the closing edge |
| rf_waddr | output | 5 | File write address |
| rf_wdata | output | 8 | File write data |
| w_out | output | 8 | Working register W |
| status_out | output | 8 | Status register, zero flag at bit 2 |
| skip_req | output | 1 | Skip the already-fetched next instruction |

## Verification
The bench builds the unit with its defaults: an 8-bit datapath, a 5-bit address for 32 file entries, and the zero flag at bit 2. With these widths every file entry can be addressed from random stimulus. Seeded entries at 0x00, 0x01 and 0xFF make both wrap points and both skip triggers reachable in the directed phase. The random phase walks entries through their wrap many times, and a reset in the middle of the run shows that W and status clear while the file contents persist.

// File: rtl/incdec_exec.sv
module incdec_exec #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter int OP_W     = 3,
  parameter int ZERO_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              op_dst,
  input  logic [DATA_W-1:0] op_lit,
  output logic [ADDR_W-1:0] rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [DATA_W-1:0] w_out,
  output logic [DATA_W-1:0] status_out,
  output logic              skip_req
);

  localparam logic [OP_W-1:0] OP_INC   = OP_W'(1);
  localparam logic [OP_W-1:0] OP_DEC   = OP_W'(2);
  localparam logic [OP_W-1:0] OP_INCSZ = OP_W'(3);
  localparam logic [OP_W-1:0] OP_DECSZ = OP_W'(4);
  localparam logic [OP_W-1:0] OP_ORL   = OP_W'(5);

  logic [DATA_W-1:0] w_q, st_q;
  logic [DATA_W-1:0] step_res, res;
  logic go, up, down, skip_kind, or_kind, stepping, w_ld, z_ld;

  assign go        = op_valid & ~rst;
  assign up        = (op_code == OP_INC) | (op_code == OP_INCSZ);
  assign down      = (op_code == OP_DEC) | (op_code == OP_DECSZ);
  assign skip_kind = (op_code == OP_INCSZ) | (op_code == OP_DECSZ);
  assign or_kind   = (op_code == OP_ORL);
  assign stepping  = up | down;

  assign step_res = up ? rf_rdata + DATA_W'(1) : rf_rdata - DATA_W'(1);
  assign res      = or_kind ? (w_q | op_lit) : step_res;

  assign rf_raddr = op_addr;
  assign rf_waddr = op_addr;
  assign rf_wdata = step_res;
  assign rf_we    = go & stepping & op_dst;
  assign skip_req = go & skip_kind & (step_res == '0);

  assign w_ld = go & ((stepping & ~op_dst) | or_kind);
  assign z_ld = go & (or_kind | (stepping & ~skip_kind));

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q  <= '0;
      st_q <= '0;
    end else begin
      if (w_ld) w_q <= res;
      if (z_ld) st_q[ZERO_BIT] <= (res == '0);
    end
  end

  assign w_out      = w_q;
  assign status_out = st_q;

endmodule

// File: rtl/incdec_exec_chk.sv
module incdec_exec_chk #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 5,
  parameter int OP_W     = 3,
  parameter int ZERO_BIT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [OP_W-1:0]   op_code,
  input logic [ADDR_W-1:0] op_addr,
  input logic              op_dst,
  input logic [DATA_W-1:0] op_lit,
  input logic [ADDR_W-1:0] rf_raddr,
  input logic [DATA_W-1:0] rf_rdata,
  input logic              rf_we,
  input logic [ADDR_W-1:0] rf_waddr,
  input logic [DATA_W-1:0] rf_wdata,
  input logic [DATA_W-1:0] w_out,
  input logic [DATA_W-1:0] status_out,
  input logic              skip_req
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (w_out == '0 && status_out == '0));

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |-> (!rf_we && !skip_req));

  a_r2_wdata_step: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (((op_code == 3'd1 || op_code == 3'd3) && rf_wdata == DATA_W'(rf_rdata + DATA_W'(1))) ||
               ((op_code == 3'd2 || op_code == 3'd4) && rf_wdata == DATA_W'(rf_rdata - DATA_W'(1)))));

  a_r3_file_dest_keeps_w: assert property (@(posedge clk) disable iff (rst)
    (rf_we && op_dst) |=> $stable(w_out));

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 3'd1 || op_code == 3'd2) && !op_dst) |=> (status_out[ZERO_BIT] == (w_out == '0)));

  a_r5_skip_status: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 3'd3 || op_code == 3'd4)) |=> $stable(status_out));

  a_r6_skip_cause: assert property (@(posedge clk) disable iff (rst)
    skip_req |-> ((op_code == 3'd3 && rf_rdata == '1) || (op_code == 3'd4 && rf_rdata == DATA_W'(1))));

  a_r7_or_result: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 3'd5) |=> (w_out == ($past(w_out) | $past(op_lit))));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !op_valid |-> (!rf_we && !skip_req));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(w_out) && $stable(status_out)));

  a_r9_addr_follow: assert property (@(posedge clk) disable iff (rst)
    (rf_raddr == op_addr) && (!rf_we || rf_waddr == op_addr));

endmodule

bind incdec_exec incdec_exec_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W), .ZERO_BIT(ZERO_BIT)
) u_chk (.*);

// File: tb/tb_incdec_exec.sv
`timescale 1ns/1ps
module tb_incdec_exec;
  logic clk = 0, rst = 1, op_valid = 0, op_dst = 0;
  logic [2:0] op_code = 0;
  logic [4:0] op_addr = 0;
  logic [7:0] op_lit = 0;
  logic [4:0] rf_raddr, rf_waddr;
  logic [7:0] rf_rdata, rf_wdata, w_out, status_out;
  logic rf_we, skip_req;

  logic [7:0] mem [32];
  int exp_mem [32];
  int exp_w = 0, exp_st = 0;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;

  incdec_exec dut (.clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_dst(op_dst), .op_lit(op_lit), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .w_out(w_out), .status_out(status_out), .skip_req(skip_req));

  assign rf_rdata = mem[rf_raddr];
  always @(posedge clk) if (rf_we) mem[rf_waddr] <= rf_wdata;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  task automatic step(input bit v, input int op, input int a, input bit d, input int lit);
    int r;
    bit incop, decop, ew, es;
    string wtag, stag;
    @(negedge clk);
    op_valid = v; op_code = 3'(op); op_addr = 5'(a); op_dst = d; op_lit = 8'(lit);
    #1;
    incop = (op == 1 || op == 3);
    decop = (op == 2 || op == 4);
    r  = incop ? (exp_mem[a] + 1) & 255 : (exp_mem[a] + 255) & 255;
    ew = v && (incop || decop) && d;
    es = v && (op == 3 || op == 4) && (r == 0);
    chk(v ? "R3" : "R8", "rf_we", int'(rf_we), int'(ew));
    if (ew) begin
      chk("R2", "rf_wdata", int'(rf_wdata), r);
      chk("R3", "rf_waddr", int'(rf_waddr), a);
    end
    chk("R6", "skip_req", int'(skip_req), int'(es));
    chk("R9", "rf_raddr", int'(rf_raddr), a);
    wtag = "R8"; stag = "R8";
    if (v && (incop || decop)) begin
      wtag = d ? "R3" : "R2";
      stag = (op == 3 || op == 4) ? "R5" : "R4";
      if (d) exp_mem[a] = r; else exp_w = r;
      if (op == 1 || op == 2) exp_st = (exp_st & ~4) | ((r == 0) ? 4 : 0);
    end else if (v && op == 5) begin
      wtag = "R7"; stag = "R7";
      exp_w = exp_w | lit;
      exp_st = (exp_st & ~4) | ((exp_w == 0) ? 4 : 0);
    end
    @(posedge clk); #1;
    chk(wtag, "w_out", int'(w_out), exp_w);
    chk(stag, "status_out", int'(status_out), exp_st);
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; op_valid = 1; op_code = 3'd1; op_addr = 5'd9; op_dst = 1;
    #1;
    chk("R1", "rf_we in reset", int'(rf_we), 0);
    chk("R1", "skip_req in reset", int'(skip_req), 0);
    @(posedge clk); #1;
    exp_w = 0; exp_st = 0;
    chk("R1", "w_out", int'(w_out), 0);
    chk("R1", "status_out", int'(status_out), 0);
    @(negedge clk);
    rst = 0; op_valid = 0;
  endtask

  initial begin
    #(200000 * 8);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mem[i] = 8'((i * 37 + 5) & 255);
      exp_mem[i] = (i * 37 + 5) & 255;
    end
    mem[3] = 8'hFF; exp_mem[3] = 255;
    mem[4] = 8'h00; exp_mem[4] = 0;
    mem[5] = 8'h01; exp_mem[5] = 1;
    mem[6] = 8'hFF; exp_mem[6] = 255;
    repeat (2) @(posedge clk);
    do_reset();

    step(1, 1, 3, 0, 0);     // R2 wrap up, R4 zero set
    step(1, 2, 4, 0, 0);     // R2 wrap down, R4 zero clear
    step(1, 3, 6, 1, 0);     // R6 skip, R5 status held
    step(1, 4, 5, 0, 0);     // R6 skip to W
    step(1, 2, 5, 1, 0);     // R3 file dest, R4 zero
    step(1, 5, 0, 1, 8'h00); // R7 OR zero, dst ignored
    step(1, 5, 0, 0, 8'h5A); // R7 OR nonzero
    step(1, 3, 7, 0, 0);     // R6 no skip
    step(0, 1, 3, 1, 0);     // R8 invalid
    step(1, 0, 3, 1, 0);     // R8 code 0
    step(1, 6, 3, 1, 0);     // R8 code 6
    step(1, 7, 4, 0, 0);     // R8 code 7

    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 8) != 0, int'($urandom % 8), int'($urandom % 32),
           1'($urandom % 2), int'($urandom % 256));
      if (n == 1500) do_reset();
    end

    @(negedge clk);
    for (int i = 0; i < 32; i++) chk("R3", "file entry", int'(mem[i]), exp_mem[i]);
    summary();
    $finish;
  end
endmodule